// File: doc/BRIEF.md
# L3 Control Bus Master

This block is the master side of a three-wire control bus (clock, data, mode) of the kind used to load the status and data registers of an audio codec. A host presents a command, made of a 6-bit device address, a 2-bit register-space selector, a data byte count and a read/write flag, over a valid/ready handshake. The block then drives one address byte, followed by the requested number of data bytes. Write bytes are pulled one at a time from a valid/ready byte stream. Read bytes are handed back as one-cycle strobes.

The mode line tells the address phase apart from the data phase. It is low for the whole address byte and high for the first data byte. Before each later data byte it is pulsed low for a halt interval. The data line only ever moves while the clock is low, so a device that shares the wires and watches for a start condition never sees one. Every interval is stated in units of 10 ns and scaled by a parameter that gives the number of system clock cycles per 10 ns. When no transaction is running, all bus outputs are released through their enables.

Top module: `l3_ctrl_master`

## Requirements
- R1: After reset, both output enables are low, `busy` is low and `cmd_ready` is high.
- R2: The address byte is `{cmd_dev, cmd_sel}`, with the selector in bits 1:0. It is shifted out least significant bit first, and mode is low at every one of its 8 rising clock edges.
- R3: Mode is high at every rising clock edge of every data byte. Before each data byte after the first, mode falls exactly once and stays low for 19*K system cycles, where K is cycles per 10 ns.
- R4: While the bus is driven, the data value and the data enable never change while the clock is high, and mode never changes while the clock is low.
- R5: Each clock-low phase lasts 19*K+1 cycles, and data is set one cycle after the clock falls, which gives at least 19*K cycles of setup. Each clock-high phase within a byte lasts 10*K cycles.
- R6: On a write, each data byte is taken from `wr_data` in a cycle where `wr_ready` and `wr_valid` are both high, and it is sent least significant bit first.
- R7: On a read, the data enable is low at the rising edges of the data bytes. The line is sampled just before each rising edge, LSB first. Each completed byte appears on `rd_data` with a one-cycle `rd_valid`, one strobe per data byte.
- R8: A transaction carries exactly 8*(count+1) rising clock edges. A count of zero sends only the address byte.
- R9: In the cycle after a command is accepted, clock, data and mode are all high and enabled. A transaction ends with a one-cycle `done`, in the same cycle that `busy` falls and both enables drop.
- R10: While `busy` is high, `cmd_ready` is low, and a command offered then has no effect on the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (idle) |
| cmd_dev | input | 6 | Device address |
| cmd_sel | input | 2 | Register space: 0 data bank 0, 1 data bank 1, 2 status |
| cmd_count | input | CNT_W | Number of data bytes |
| cmd_rd | input | 1 | 1 = read data bytes, 0 = write |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| bus_clk_o | output | 1 | Bus clock value |
| bus_mode_o | output | 1 | Bus mode value |
| bus_ctl_oe | output | 1 | Enable for clock and mode |
| bus_dat_o | output | 1 | Bus data value |
| bus_dat_oe | output | 1 | Enable for data |
| bus_dat_i | input | 1 | Bus data as seen on the pin |

## Verification
The assertions assume that `bus_dat_i` settles before the clock rises, and that the host keeps the command fields steady in the cycle it raises `cmd_valid`. The bench's slave model updates the read bit only just after a rising edge. The bench sets the command fields a half cycle before the accepting edge. It also offers a conflicting command while busy, to show that this command is refused. The write stream is always valid, so the fetch state never stalls for long.

// File: rtl/l3_ctrl_master.sv
module l3_ctrl_master #(
  parameter int CYC_PER_10NS = 1,
  parameter int CNT_W        = 8,
  parameter int LOW_U        = 10,
  parameter int HIGH_U       = 10,
  parameter int DSU_U        = 19,
  parameter int MSU_U        = 19,
  parameter int MHD_U        = 19,
  parameter int HALT_U       = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [5:0]       cmd_dev,
  input  logic [1:0]       cmd_sel,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             cmd_rd,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             bus_clk_o,
  output logic             bus_mode_o,
  output logic             bus_ctl_oe,
  output logic             bus_dat_o,
  output logic             bus_dat_oe,
  input  logic             bus_dat_i
);

  localparam int K     = CYC_PER_10NS;
  localparam int T_LOW = ((LOW_U > DSU_U) ? LOW_U : DSU_U) * K + 1;
  localparam int T_HI  = HIGH_U * K;
  localparam int T_MSU = MSU_U * K;
  localparam int T_MHD = MHD_U * K;
  localparam int T_HLT = HALT_U * K;
  localparam int T_MAX = (T_LOW > T_MSU) ? T_LOW : T_MSU;
  localparam int TW    = $clog2(T_MAX + 1) + 2;

  typedef enum logic [2:0] {
    S_IDLE, S_ACQ, S_MSET, S_FETCH, S_LOW, S_HIGH, S_HOLD, S_HALT
  } st_t;

  st_t             st;
  logic [TW-1:0]   tmr;
  logic [2:0]      bitn;
  logic [CNT_W-1:0] left;
  logic            is_addr, rdm, first;
  logic [7:0]      sh;
  logic            clk_q, mode_q, dat_q, ctl_oe_q, dat_oe_q;
  logic            done_q, rdv_q;
  logic [7:0]      rdd_q;

  wire expired   = (tmr == '0);
  wire rd_byte   = rdm && !is_addr;

  assign cmd_ready  = (st == S_IDLE);
  assign busy       = (st != S_IDLE);
  assign wr_ready   = (st == S_FETCH);
  assign done       = done_q;
  assign rd_valid   = rdv_q;
  assign rd_data    = rdd_q;
  assign bus_clk_o  = clk_q;
  assign bus_mode_o = mode_q;
  assign bus_dat_o  = dat_q;
  assign bus_ctl_oe = ctl_oe_q;
  assign bus_dat_oe = dat_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      bitn     <= '0;
      left     <= '0;
      is_addr  <= 1'b0;
      rdm      <= 1'b0;
      first    <= 1'b0;
      sh       <= '0;
      clk_q    <= 1'b1;
      mode_q   <= 1'b1;
      dat_q    <= 1'b1;
      ctl_oe_q <= 1'b0;
      dat_oe_q <= 1'b0;
      done_q   <= 1'b0;
      rdv_q    <= 1'b0;
      rdd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      if (!expired) tmr <= tmr - 1'b1;
      unique case (st)
        S_IDLE: if (cmd_valid) begin
          sh       <= {cmd_dev, cmd_sel};
          left     <= cmd_count;
          rdm      <= cmd_rd;
          is_addr  <= 1'b1;
          clk_q    <= 1'b1;
          mode_q   <= 1'b1;
          dat_q    <= 1'b1;
          ctl_oe_q <= 1'b1;
          dat_oe_q <= 1'b1;
          tmr      <= TW'(T_MSU - 1);
          st       <= S_ACQ;
        end
        S_ACQ: if (expired) begin
          mode_q <= 1'b0;
          tmr    <= TW'(T_MSU - 1);
          st     <= S_MSET;
        end
        S_MSET: if (expired) begin
          clk_q <= 1'b0;
          bitn  <= '0;
          first <= 1'b1;
          tmr   <= TW'(T_LOW - 1);
          st    <= S_LOW;
        end
        S_FETCH: if (wr_valid) begin
          sh  <= wr_data;
          tmr <= TW'(T_MSU - 1);
          st  <= S_MSET;
        end
        S_LOW: begin
          if (first) begin
            first <= 1'b0;
            if (rd_byte) dat_oe_q <= 1'b0;
            else         dat_q    <= sh[0];
          end
          if (expired) begin
            clk_q <= 1'b1;
            sh    <= rd_byte ? {bus_dat_i, sh[7:1]} : {1'b0, sh[7:1]};
            tmr   <= TW'(T_HI - 1);
            st    <= S_HIGH;
          end
        end
        S_HIGH: if (expired) begin
          if (bitn == 3'd7) begin
            if (is_addr) mode_q <= 1'b1;
            tmr <= TW'(T_MHD - 1);
            st  <= S_HOLD;
          end else begin
            bitn  <= bitn + 1'b1;
            clk_q <= 1'b0;
            first <= 1'b1;
            tmr   <= TW'(T_LOW - 1);
            st    <= S_LOW;
          end
        end
        S_HOLD: if (expired) begin
          if (rd_byte) begin
            rdv_q <= 1'b1;
            rdd_q <= sh;
          end
          if (left == '0) begin
            ctl_oe_q <= 1'b0;
            dat_oe_q <= 1'b0;
            done_q   <= 1'b1;
            st       <= S_IDLE;
          end else if (is_addr) begin
            is_addr <= 1'b0;
            left    <= left - 1'b1;
            tmr     <= TW'(T_MSU - 1);
            st      <= rdm ? S_MSET : S_FETCH;
          end else begin
            left   <= left - 1'b1;
            mode_q <= 1'b0;
            tmr    <= TW'(T_HLT - 1);
            st     <= S_HALT;
          end
        end
        S_HALT: if (expired) begin
          mode_q <= 1'b1;
          tmr    <= TW'(T_MSU - 1);
          st     <= rdm ? S_MSET : S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [TW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_run <= '0;
    else if (clk_q)  low_run <= '0;
    else if (low_run != '1) low_run <= low_run + 1'b1;
  end

  assert_dat_still_clk_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe_q && $past(ctl_oe_q) && clk_q && $past(clk_q)) |-> ($stable(dat_q) && $stable(dat_oe_q)));

  assert_mode_still_clk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe_q && $past(ctl_oe_q) && !clk_q) |-> $stable(mode_q));

  assert_low_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |-> (low_run >= TW'(T_LOW)));

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy && $past(busy) && !ctl_oe_q && !dat_oe_q));

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ctl_oe_q && !dat_oe_q));

  assert_rd_only_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdv_q |-> rdm);

endmodule

// File: tb/l3_ctrl_master_tb.sv
module l3_ctrl_master_tb_top;
  localparam int K = 1;
  localparam int TLOW = 19 * K + 1;
  localparam int THI  = 10 * K;
  localparam int THLT = 19 * K;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cmd_valid = 1'b0, cmd_rd = 1'b0, wr_valid = 1'b1;
  logic [5:0] cmd_dev = '0;
  logic [1:0] cmd_sel = '0;
  logic [7:0] cmd_count = '0, wr_data = '0;
  logic cmd_ready, wr_ready, rd_valid, busy, done;
  logic [7:0] rd_data;
  logic bclk, bmode, bctl_oe, bdat, bdat_oe;
  logic bdat_i = 1'b0;

  l3_ctrl_master #(.CYC_PER_10NS(K), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dev(cmd_dev), .cmd_sel(cmd_sel), .cmd_count(cmd_count), .cmd_rd(cmd_rd),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
    .bus_clk_o(bclk), .bus_mode_o(bmode), .bus_ctl_oe(bctl_oe),
    .bus_dat_o(bdat), .bus_dat_oe(bdat_oe), .bus_dat_i(bdat_i));

  int errors = 0, checks = 0;

  function automatic logic [7:0] wpat(int k, logic [7:0] a);
    return 8'h3C ^ 8'(k * 29) ^ a;
  endfunction
  function automatic logic [7:0] rpat(int k, logic [5:0] d);
    return 8'hA5 ^ 8'(k * 37) ^ {2'b00, d};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  logic bitv[64], modv[64], oev[64];
  logic [7:0] rdg[16];
  int nrise, nrd, ndone, nfall, viol, minlow, minhigh, minhalt;
  int lowrun, highrun, mlowrun;
  logic p_clk, p_mode, p_dat, p_doe, p_oe;
  logic [5:0] cur_dev;

  always @(negedge clk) begin
    if (cmd_valid && cmd_ready) begin
      nrise = 0; nrd = 0; ndone = 0; nfall = 0; viol = 0;
      minlow = 9999; minhigh = 9999; minhalt = 9999;
      lowrun = 0; highrun = 0; mlowrun = 0; cur_dev = cmd_dev;
    end
    if (bctl_oe) begin
      if (p_oe) begin
        if (bclk && p_clk && (bdat !== p_dat || bdat_oe !== p_doe)) viol++;
        if (!bclk && bmode !== p_mode) viol++;
        if (p_mode && !bmode) nfall++;
        if (bclk && !p_clk) begin
          if (lowrun < minlow) minlow = lowrun;
          bitv[nrise] = bdat; modv[nrise] = bmode; oev[nrise] = bdat_oe;
          nrise++;
        end
        if (!bclk && p_clk && highrun < minhigh) minhigh = highrun;
        if (bmode && !p_mode && nfall >= 2 && mlowrun < minhalt) minhalt = mlowrun;
      end
      if (!bclk) begin lowrun++; highrun = 0; end else begin highrun++; lowrun = 0; end
      if (!bmode) mlowrun++; else mlowrun = 0;
    end
    if (rd_valid) begin rdg[nrd] = rd_data; nrd++; end
    if (done) ndone++;
    if (nrise >= 8) bdat_i = rpat((nrise - 8) / 8, cur_dev)[(nrise - 8) % 8];
    else            bdat_i = 1'b0;
    p_clk = bclk; p_mode = bmode; p_dat = bdat; p_doe = bdat_oe; p_oe = bctl_oe;
  end

  int widx = 0;
  logic [7:0] waddr = '0;
  initial begin
    forever begin
      bit take;
      @(negedge clk);
      take = wr_valid && wr_ready;
      @(posedge clk);
      #1;
      if (take) widx++;
      wr_data = wpat(widx, waddr);
    end
  end

  task automatic txn(logic [5:0] dv, logic [1:0] sl, int cnt, logic rd);
    logic [7:0] ab;
    int wd;
    bit ok;
    ab = {dv, sl};
    @(negedge clk);
    widx = 0; waddr = ab; wr_data = wpat(0, ab);
    cmd_dev = dv; cmd_sel = sl; cmd_count = 8'(cnt); cmd_rd = rd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && bctl_oe && bdat_oe && bclk && bdat && bmode, "R9", "driven high at start",
        {busy, bctl_oe, bdat_oe, bclk, bdat, bmode}, 6'h3F);
    cmd_dev = ~dv; cmd_sel = 2'd1; cmd_count = 8'd9; cmd_rd = ~rd; cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cmd_ready, "R10", "ready low while busy", cmd_ready, 0);
    cmd_valid = 1'b0;
    wd = 0;
    while (!done && wd < 20000) begin @(negedge clk); wd++; end
    if (wd >= 20000) begin
      chk(0, "R9", "watchdog expired", wd, 0);
      return;
    end
    chk(!busy && !bctl_oe && !bdat_oe, "R9", "released at done", {busy, bctl_oe, bdat_oe}, 0);
    @(negedge clk);
    chk(!done && ndone == 1, "R9", "single done pulse", ndone, 1);
    chk(nrise == 8 * (cnt + 1), "R8", "rising edge count", nrise, 8 * (cnt + 1));
    if (nrise != 8 * (cnt + 1)) return;
    ok = 1;
    for (int i = 0; i < 8; i++) if (bitv[i] !== ab[i] || modv[i] !== 1'b0) ok = 0;
    chk(ok, "R2", "address bits LSB first with mode low", {bitv[7], bitv[6], bitv[5], bitv[4], bitv[3], bitv[2], bitv[1], bitv[0]}, ab);
    ok = 1;
    for (int i = 8; i < nrise; i++) if (modv[i] !== 1'b1) ok = 0;
    chk(ok, "R3", "mode high in data bytes", ok, 1);
    chk(nfall == 1 + ((cnt > 1) ? cnt - 1 : 0), "R3", "mode fall count", nfall, 1 + ((cnt > 1) ? cnt - 1 : 0));
    if (cnt > 1) chk(minhalt == THLT, "R3", "halt width", minhalt, THLT);
    chk(viol == 0, "R4", "line change against clock level", viol, 0);
    chk(minlow == TLOW, "R5", "clock low width", minlow, TLOW);
    chk(minhigh == THI, "R5", "clock high width", minhigh, THI);
    if (!rd) begin
      for (int k = 0; k < cnt; k++) begin
        logic [7:0] got;
        for (int b = 0; b < 8; b++) got[b] = bitv[8 + 8 * k + b];
        chk(got == wpat(k, ab), "R6", "write byte", got, wpat(k, ab));
      end
      chk(nrd == 0, "R7", "no read strobes on write", nrd, 0);
    end else begin
      chk(nrd == cnt, "R7", "read strobe count", nrd, cnt);
      ok = 1;
      for (int i = 8; i < nrise; i++) if (oev[i] !== 1'b0) ok = 0;
      chk(ok, "R7", "data released during read", ok, 1);
      for (int k = 0; k < cnt && k < nrd; k++)
        chk(rdg[k] == rpat(k, dv), "R7", "read byte", rdg[k], rpat(k, dv));
    end
  endtask

  initial begin
    logic [5:0] devs[3];
    devs[0] = 6'h05; devs[1] = 6'h2A; devs[2] = 6'h3F;
    repeat (3) @(negedge clk);
    chk(!bctl_oe && !bdat_oe && !busy && cmd_ready, "R1", "reset state",
        {bctl_oe, bdat_oe, busy, cmd_ready}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bctl_oe && !bdat_oe && !busy && cmd_ready, "R1", "idle after reset",
        {bctl_oe, bdat_oe, busy, cmd_ready}, 1);
    for (int d = 0; d < 3; d++)
      for (int s = 0; s < 3; s++)
        for (int c = 0; c < 4; c++)
          for (int r = 0; r < 2; r++)
            txn(devs[d], 2'(s), c, 1'(r));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1900000;
    errors++; checks++;
    $display("FAIL R9 global watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule